// File: doc/BRIEF.md
# Flow Entry Destination Resolver

This block sits after a flow-table lookup in a receive path. It takes the routing word of the entry the lookup returned, together with a few facts about the current packet, and chooses the exit ring the frame is sent to. It also reports whether the flow search counts as failed and whether the frame is to be dropped. An entry can ask for a drop, which sends the frame to the release ring. It can ask for the engine-offload ring, which is not granted for multi-buffer packets when that suppression is enabled. Otherwise a two-bit handler field picks the source of the destination: the entry itself, the address-search result, or a classification super-rule.

A "destination-invalid" mode covers fragmented traffic. When a first fragment hits an entry, the block asks the entry memory to set the entry's invalid bit. After that, any hit on that entry is treated as a routing miss. On a miss, the address-search destination is used. Ring codes above 10, and codes for software rings that the build does not implement, are replaced by a configurable default ring. The result leaves through one output register with a valid/ready handshake.

Top module: `flow_dest_resolver`

## Requirements
- R1: A hit requires both `lkp_hit` and bit 8 of `rt_word`. On a miss the ring comes from `as_dest`, `fs_fail` is 1 and `drop` is 0.
- R2: On a good hit with no override, `rt_word[31:30]` selects the ring source. The values 0 and 2 select the entry's destination in `rt_word[28:24]`, 1 selects `as_dest`, and 3 selects `rule_dest`.
- R3: On a good hit with `rt_word[29]` set, the ring is 5 (the release ring) and `drop` is 1. This holds even when the offload bit is also set.
- R4: On a good hit with `rt_word[23]` set and no drop, the ring is `cfg_ofl_ring`. This holds whatever the handler and destination fields say.
- R5: When `cfg_mbuf_no_ofl` is 1 and `mbuf` is 1, the offload bit has no effect and handler selection applies. When `cfg_mbuf_no_ofl` is 0, multi-buffer packets still take the offload ring.
- R6: Codes 0 to 6 pass through unchanged. Codes 7 to 10 name software rings 5 to 8. Such a code passes only if its ring is among the `SW_RINGS` implemented, and is otherwise replaced by `cfg_dflt_ring`.
- R7: Any selected code from 11 to 31 is replaced by `cfg_dflt_ring`.
- R8: When `cfg_inv_mode` is 1, a good hit with `first_frag` = 1 on an entry whose `ent_inv` = 0 sets `set_inv` to 1 and routes normally. No other case sets `set_inv`.
- R9: When `cfg_inv_mode` is 1, a hit on an entry with `ent_inv` = 1 is a failed search. It routes as a miss, with `fs_fail` = 1, `drop` = 0 and `set_inv` = 0. When `cfg_inv_mode` is 0, `ent_inv` is ignored.
- R10: An accepted input appears at the outputs one cycle later. The outputs hold while `out_valid` = 1 and `out_ready` = 0. `in_ready` equals `!out_valid || out_ready`.
- R11: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Input accepted this cycle when high |
| rt_word | input | 32 | Entry routing word |
| lkp_hit | input | 1 | Lookup found an entry |
| ent_inv | input | 1 | Entry's destination-invalid bit |
| first_frag | input | 1 | Packet is a first fragment |
| mbuf | input | 1 | Packet uses several buffers |
| as_dest | input | 5 | Address-search fallback ring code |
| rule_dest | input | 5 | Classification super-rule ring code |
| cfg_ofl_ring | input | 5 | Engine-offload ring code |
| cfg_dflt_ring | input | 5 | Ring used for unmapped codes |
| cfg_mbuf_no_ofl | input | 1 | Suppress offload for multi-buffer packets |
| cfg_inv_mode | input | 1 | Enable destination-invalid mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| ring | output | 5 | Resolved ring code |
| drop | output | 1 | Frame goes to release ring by drop |
| fs_fail | output | 1 | Flow search counts as failed |
| set_inv | output | 1 | Request to set the entry's invalid bit |

## Verification
The bench builds the block with `SW_RINGS` = 7, so software rings 5 and 6 exist and rings 7 and 8 do not. With that build, codes 7 and 8 must pass through while codes 9 and 10 fold to the default ring. Both sides of the R6 boundary are therefore reachable in one build. The offload ring is set to 9 in one vector, which shows that the programmed offload value is also remapped. The default ring is set to 2 so that the fold is distinguishable from the release ring and from the fallback codes used.

// File: rtl/flow_dest_resolver.sv
module flow_dest_resolver #(
  parameter int SW_RINGS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [31:0] rt_word,
  input  logic       lkp_hit,
  input  logic       ent_inv,
  input  logic       first_frag,
  input  logic       mbuf,
  input  logic [4:0] as_dest,
  input  logic [4:0] rule_dest,
  input  logic [4:0] cfg_ofl_ring,
  input  logic [4:0] cfg_dflt_ring,
  input  logic       cfg_mbuf_no_ofl,
  input  logic       cfg_inv_mode,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [4:0] ring,
  output logic       drop,
  output logic       fs_fail,
  output logic       set_inv
);
  localparam int        EXTRA_SW  = (SW_RINGS > 5) ? SW_RINGS - 5 : 0;
  localparam logic [4:0] LAST_CODE = 5'(6 + EXTRA_SW);
  localparam logic [4:0] REL_CODE  = 5'd5;

  function automatic logic [4:0] remap(input logic [4:0] c, input logic [4:0] dflt);
    if (c <= 5'd6) return c;
    if (c >= 5'd7 && c <= LAST_CODE) return c;
    return dflt;
  endfunction

  wire       e_valid = rt_word[8];
  wire       e_ofl   = rt_word[23];
  wire [4:0] e_dest  = rt_word[28:24];
  wire       e_drop  = rt_word[29];
  wire [1:0] e_hndl  = rt_word[31:30];

  wire hit     = lkp_hit && e_valid;
  wire blocked = hit && cfg_inv_mode && ent_inv;
  wire good    = hit && !blocked;
  wire use_ofl = e_ofl && !(cfg_mbuf_no_ofl && mbuf);

  logic [4:0] sel_code;
  always_comb begin
    if (!good)          sel_code = as_dest;
    else if (use_ofl)   sel_code = cfg_ofl_ring;
    else begin
      case (e_hndl)
        2'd1:    sel_code = as_dest;
        2'd3:    sel_code = rule_dest;
        default: sel_code = e_dest;
      endcase
    end
  end

  wire [4:0] nxt_ring = (good && e_drop) ? REL_CODE : remap(sel_code, cfg_dflt_ring);
  wire       nxt_drop = good && e_drop;
  wire       nxt_set  = good && cfg_inv_mode && first_frag && !ent_inv;

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ring      <= '0;
      drop      <= 1'b0;
      fs_fail   <= 1'b0;
      set_inv   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        ring      <= nxt_ring;
        drop      <= nxt_drop;
        fs_fail   <= !good;
        set_inv   <= nxt_set;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r3_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && drop |-> ring == REL_CODE);

  a_r9_fail_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fs_fail |-> !drop && !set_inv);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ring) && $stable(drop) && $stable(fs_fail) && $stable(set_inv));

  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_miss_fail: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !lkp_hit |=> out_valid && fs_fail);

  a_r8_set_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_inv_mode |=> !set_inv);
endmodule

// File: tb/test_flow_dest_resolver.sv
`timescale 1ns/1ps
module test_flow_dest_resolver;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, lkp_hit, ent_inv, first_frag, mbuf;
  logic [31:0] rt_word;
  logic [4:0] as_dest, rule_dest, cfg_ofl_ring, cfg_dflt_ring, ring;
  logic cfg_mbuf_no_ofl, cfg_inv_mode, out_valid, out_ready, drop, fs_fail, set_inv;

  flow_dest_resolver #(.SW_RINGS(7)) i_flow_dest_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rt_word(rt_word), .lkp_hit(lkp_hit), .ent_inv(ent_inv), .first_frag(first_frag),
    .mbuf(mbuf), .as_dest(as_dest), .rule_dest(rule_dest), .cfg_ofl_ring(cfg_ofl_ring),
    .cfg_dflt_ring(cfg_dflt_ring), .cfg_mbuf_no_ofl(cfg_mbuf_no_ofl), .cfg_inv_mode(cfg_inv_mode),
    .out_valid(out_valid), .out_ready(out_ready), .ring(ring), .drop(drop),
    .fs_fail(fs_fail), .set_inv(set_inv));

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] word;
    logic        hit, ff, mb, einv, mode, sup;
    logic [4:0]  asd, rule, ofl;
    logic [4:0]  e_ring;
    logic        e_drop, e_fail, e_set;
  } vec_t;

  function automatic logic [31:0] mk(input logic [1:0] h, input logic dr,
                                     input logic [4:0] d, input logic of, input logic v);
    return {h, dr, d, of, 14'd0, v, 8'h06};
  endfunction

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd1, mk(2'd0,1'b0,5'd3,1'b0,1'b1), 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd0,5'd8, 5'd1,1'b0,1'b1,1'b0}, // R1 no lookup hit
    '{4'd1, mk(2'd0,1'b1,5'd3,1'b0,1'b0), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd4,5'd0,5'd8, 5'd4,1'b0,1'b1,1'b0}, // R1 valid bit clear
    '{4'd2, mk(2'd0,1'b0,5'd3,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd7,5'd8, 5'd3,1'b0,1'b0,1'b0}, // R2 handler 0
    '{4'd2, mk(2'd1,1'b0,5'd3,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd6,5'd7,5'd8, 5'd6,1'b0,1'b0,1'b0}, // R2 handler 1
    '{4'd2, mk(2'd2,1'b0,5'd0,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd6,5'd7,5'd8, 5'd0,1'b0,1'b0,1'b0}, // R2 handler 2
    '{4'd2, mk(2'd3,1'b0,5'd0,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd6,5'd7,5'd8, 5'd7,1'b0,1'b0,1'b0}, // R2 handler 3
    '{4'd3, mk(2'd0,1'b1,5'd3,1'b1,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd7,5'd8, 5'd5,1'b1,1'b0,1'b0}, // R3 drop beats offload
    '{4'd3, mk(2'd1,1'b1,5'd3,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd7,5'd8, 5'd5,1'b1,1'b0,1'b0}, // R3 drop beats handler
    '{4'd4, mk(2'd3,1'b0,5'd3,1'b1,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd8,1'b0,1'b0,1'b0}, // R4 offload ring
    '{4'd4, mk(2'd0,1'b0,5'd3,1'b1,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd9, 5'd2,1'b0,1'b0,1'b0}, // R4 offload value remapped
    '{4'd5, mk(2'd0,1'b0,5'd4,1'b1,1'b1), 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 5'd1,5'd1,5'd8, 5'd4,1'b0,1'b0,1'b0}, // R5 suppressed
    '{4'd5, mk(2'd0,1'b0,5'd4,1'b1,1'b1), 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd8,1'b0,1'b0,1'b0}, // R5 not suppressed
    '{4'd6, mk(2'd0,1'b0,5'd8,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd8,1'b0,1'b0,1'b0}, // R6 ring 6 present
    '{4'd6, mk(2'd0,1'b0,5'd9,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd2,1'b0,1'b0,1'b0}, // R6 ring 7 absent
    '{4'd6, mk(2'd0,1'b0,5'd6,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd6,1'b0,1'b0,1'b0}, // R6 code 6 passes
    '{4'd7, mk(2'd1,1'b0,5'd0,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 5'd31,5'd1,5'd8, 5'd2,1'b0,1'b0,1'b0}, // R7 code 31
    '{4'd8, mk(2'd0,1'b0,5'd3,1'b0,1'b1), 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 5'd1,5'd1,5'd8, 5'd3,1'b0,1'b0,1'b1}, // R8 first fragment hit
    '{4'd9, mk(2'd0,1'b1,5'd3,1'b0,1'b1), 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 5'd1,5'd1,5'd8, 5'd1,1'b0,1'b1,1'b0}, // R9 later hit fails
    '{4'd9, mk(2'd0,1'b0,5'd3,1'b0,1'b1), 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 5'd1,5'd1,5'd8, 5'd1,1'b0,1'b1,1'b0}, // R9 first frag on marked entry
    '{4'd9, mk(2'd0,1'b0,5'd3,1'b0,1'b1), 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 5'd1,5'd1,5'd8, 5'd3,1'b0,1'b0,1'b0}  // R9 mode off ignores bit
  };

  task automatic chk(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rt_word = v.word; lkp_hit = v.hit; first_frag = v.ff; mbuf = v.mb;
    ent_inv = v.einv; cfg_inv_mode = v.mode; cfg_mbuf_no_ofl = v.sup;
    as_dest = v.asd; rule_dest = v.rule; cfg_ofl_ring = v.ofl;
  endtask

  task automatic expect_vec(input vec_t v);
    chk("out_valid", int'(v.req), int'(out_valid), 1);
    chk("ring", int'(v.req), int'(ring), int'(v.e_ring));
    chk("drop", int'(v.req), int'(drop), int'(v.e_drop));
    chk("fs_fail", int'(v.req), int'(fs_fail), int'(v.e_fail));
    chk("set_inv", int'(v.req), int'(set_inv), int'(v.e_set));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; cfg_dflt_ring = 5'd2;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    chk("reset out_valid", 11, int'(out_valid), 0); // R11
    chk("reset in_ready", 10, int'(in_ready), 1);   // R10
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      expect_vec(VEC[i]);
    end
    @(negedge clk);
    chk("idle out_valid", 10, int'(out_valid), 0); // R10
    // R10 backpressure: hold result A, offer B
    out_ready = 1'b0;
    drive(VEC[2]); in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[3]);
    chk("in_ready under stall", 10, int'(in_ready), 0);
    @(negedge clk);
    expect_vec(VEC[2]);
    @(negedge clk);
    expect_vec(VEC[2]);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_vec(VEC[3]);
    @(negedge clk);
    chk("drained out_valid", 10, int'(out_valid), 0); // R10
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule